// File: doc/BRIEF.md
# Keyed Register Write Guard

This block protects a peripheral's register file from stray or runaway writes. It sits on a simple write port (byte offset, 32-bit data, write strobe) in front of the protected registers. It turns each accepted write into a one-hot write enable for the target register, plus a copy of the data. While the guard is closed, writes to protected offsets are discarded without any side effect, and a saturating counter records how many were discarded.

Software opens the guard by writing two fixed 32-bit key words, in order, to two dedicated key offsets. Any other value written to either key closes it again. Writing zero is the usual way to relock. Reads do not pass through this block and are never restricted. The registers, time keeping and alarm matching are outside this block.

Top module: `keyed_write_guard`

## Requirements
- R1: While reset is held, and in the first cycle after it, `locked` is 1, `reg_we` is all zero and `drop_count` is 0.
- R2: The protected map gives index 0-5 to offsets 0x00-0x14 (step 4, the time registers) and 6-11 to 0x20-0x34 (first alarm). It gives 12 to 0x40 (control), 13 to 0x44 (status), 14 to 0x48 (interrupt enables) and 15 to 0x54 (oscillator). It gives 16 to 0x7C (wake enable), 17-22 to 0x80-0x94 (second alarm) and 23 to 0x98 (power control). An accepted write raises only `reg_we[index]`, for one cycle, in the cycle after the write is sampled.
- R3: The guard opens when 0x83E70B13 is written to offset 0x6C and 0x95A4F1E0 is then written to offset 0x70. `locked` reads 0 in the cycle after the second key write.
- R4: Writing the second key word without the first one before it leaves the guard closed. So does writing only the first key word.
- R5: Writing any value other than its key word to either key offset, zero included, closes the guard. `locked` reads 1 in the cycle after that write.
- R6: While closed, a write to a protected offset raises no `reg_we` bit, and `drop_count` is one higher in the next cycle.
- R7: A write to an offset outside the map and outside the two key offsets raises no `reg_we` bit and leaves `drop_count` unchanged, whether the guard is open or closed.
- R8: Writes to the key offsets are always accepted by the guard logic, raise no `reg_we` bit and are never counted as dropped.
- R9: In the cycle where a `reg_we` bit is high, `reg_wdata` equals the data of the write that caused it.
- R10: `drop_count` stops at its all-ones value and holds there when further writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| reg_we | output | 24 | One-hot write enable per protected register |
| reg_wdata | output | 32 | Data that goes with `reg_we` |
| locked | output | 1 | 1 while the guard is closed |
| drop_count | output | CNT_W | Saturating count of discarded writes |

## Verification
Every result arrives one clock after the edge that samples the write. This holds for the write enable and its data, the new lock state after a key write, and the counter step after a dropped write. The driver presents each write at a falling edge and pushes the expected enable, data, lock flag and count into a queue. The monitor pops one entry per cycle, 2 ns after the following rising edge, so each comparison lands on the first cycle where the registered result is valid. Idle cycles push their own entries, which shows that an enable lasts only one cycle.

// File: rtl/keyed_write_guard_pkg.sv
// Package: shared constants, key words, lock states and the offset map.
package keyed_write_guard_pkg;

    localparam int          DATA_W   = 32;
    localparam int          NREG     = 24;
    localparam logic [7:0]  KEY_A_OFS = 8'h6C;
    localparam logic [7:0]  KEY_B_OFS = 8'h70;
    localparam logic [31:0] KEY_A_VAL = 32'h83E7_0B13;
    localparam logic [31:0] KEY_B_VAL = 32'h95A4_F1E0;

    typedef enum logic [1:0] {
        GS_CLOSED = 2'd0,   // no valid key seen
        GS_ARMED  = 2'd1,   // first key seen, still closed
        GS_OPEN   = 2'd2    // both keys in order, writes pass
    } guard_state_t;

    // Byte offset of protected register number idx (index order is the output order)
    function automatic logic [7:0] reg_offset(input int idx);
        logic [7:0] ofs;
        if (idx < 6)        ofs = 8'(idx * 4);
        else if (idx < 12)  ofs = 8'(8'h20 + (idx - 6) * 4);
        else if (idx == 12) ofs = 8'h40;
        else if (idx == 13) ofs = 8'h44;
        else if (idx == 14) ofs = 8'h48;
        else if (idx == 15) ofs = 8'h54;
        else if (idx == 16) ofs = 8'h7C;
        else if (idx < 23)  ofs = 8'(8'h80 + (idx - 17) * 4);
        else                ofs = 8'h98;
        return ofs;
    endfunction

endpackage

// File: rtl/guard_addr_decode.sv
// Module: guard_addr_decode
// Purpose: combinational offset decode into one hit line per protected
//          register and one per key offset.
// Assumes: offsets are byte addresses; ADDR_W is at least 8.
module guard_addr_decode
    import keyed_write_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   reg_hit,
    output logic              key_a_hit,
    output logic              key_b_hit
);

    // One comparator per protected register, offset taken from the package map
    for (genvar g = 0; g < NREG; g++) begin : g_hit
        localparam logic [7:0] OFS = reg_offset(g);
        assign reg_hit[g] = (addr == ADDR_W'(OFS));
    end

    // Key offset comparators
    assign key_a_hit = (addr == ADDR_W'(KEY_A_OFS));
    assign key_b_hit = (addr == ADDR_W'(KEY_B_OFS));

endmodule

// File: rtl/guard_key_fsm.sv
// Module: guard_key_fsm
// Purpose: three-state lock machine fed by writes to the two key offsets.
// Assumes: at most one write per cycle; key hits are mutually exclusive.
module guard_key_fsm
    import keyed_write_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              key_a_hit,
    input  logic              key_b_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic              is_open
);

    guard_state_t state_q, state_d;

    // Next state: a correct word advances or holds, any other word closes
    always_comb begin
        state_d = state_q;
        if (wr_en && key_a_hit) begin
            if (wr_data != KEY_A_VAL)      state_d = GS_CLOSED;
            else if (state_q == GS_CLOSED) state_d = GS_ARMED;
        end else if (wr_en && key_b_hit) begin
            if (wr_data != KEY_B_VAL)      state_d = GS_CLOSED;
            else if (state_q == GS_ARMED)  state_d = GS_OPEN;
        end
    end

    // State register with synchronous reset to closed
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_CLOSED;
        else        state_q <= state_d;
    end

    assign is_open = (state_q == GS_OPEN);

    // R3: opening only ever follows a correct second-key write
    a_r3_open_after_key_b : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_open) |-> $past(wr_en && key_b_hit && wr_data == KEY_B_VAL));

    // R5: a zero key write always leaves the guard closed
    a_r5_zero_key_closes : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (key_a_hit || key_b_hit) && wr_data == '0) |=> !is_open);

    // R4: the guard cannot open directly from the closed state
    a_r4_no_skip_key_a : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_CLOSED) |=> (state_q != GS_OPEN));

endmodule

// File: rtl/guard_drop_counter.sv
// Module: guard_drop_counter
// Purpose: saturating count of discarded protected writes.
// Assumes: at most one increment request per cycle.
module guard_drop_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Increment until all ones, then hold
    always_ff @(posedge clk) begin
        if (!rst_n)                       count <= '0;
        else if (inc && count != CNT_MAX) count <= count + CNT_W'(1);
    end

    // R6: the count never moves by more than one per cycle, and never down
    a_r6_single_step : assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

    // R10: once saturated the count stays put
    a_r10_saturate_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX));

endmodule

// File: rtl/keyed_write_guard.sv
// Module: keyed_write_guard
// Purpose: top of the write guard; decodes the offset, consults the key
//          lock and issues registered one-hot write enables.
// Assumes: single write port, one write per cycle; reads bypass this block.
module keyed_write_guard
    import keyed_write_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [NREG-1:0]   reg_we,
    output logic [31:0]       reg_wdata,
    output logic              locked,
    output logic [CNT_W-1:0]  drop_count
);

    logic [NREG-1:0] reg_hit;
    logic            key_a_hit, key_b_hit;
    logic            is_open;
    logic            drop_req;

    guard_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr      (wr_addr),
        .reg_hit   (reg_hit),
        .key_a_hit (key_a_hit),
        .key_b_hit (key_b_hit)
    );

    guard_key_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .key_a_hit (key_a_hit),
        .key_b_hit (key_b_hit),
        .wr_data   (wr_data),
        .is_open   (is_open)
    );

    // A protected write that arrives while closed is discarded and counted
    assign drop_req = wr_en && !is_open && (|reg_hit);

    guard_drop_counter #(.CNT_W(CNT_W)) u_drops (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (drop_req),
        .count (drop_count)
    );

    // Registered enable and data toward the register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we    <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= (wr_en && is_open) ? reg_hit : '0;
            if (wr_en) reg_wdata <= wr_data;
        end
    end

    assign locked = !is_open;

    // R2: never more than one register enabled in a cycle
    a_r2_onehot_we : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_we));

    // R6: nothing reaches the register file from a write made while closed
    a_r6_closed_blocks : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && locked) |=> (reg_we == '0));

    // R8: key writes never produce an enable
    a_r8_key_no_we : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (key_a_hit || key_b_hit)) |=> (reg_we == '0));

    // R9: an enable always carries the data of the write sampled one cycle earlier
    a_r9_data_follows : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !locked && (|reg_hit)) |=> (reg_wdata == $past(wr_data)));

endmodule

// File: tb/test_keyed_write_guard.sv
module test_keyed_write_guard;

    localparam int CW   = 4;
    localparam int NR   = 24;
    localparam logic [31:0] KA = 32'h83E7_0B13;
    localparam logic [31:0] KB = 32'h95A4_F1E0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [NR-1:0] reg_we;
    logic [31:0]   reg_wdata;
    logic          locked;
    logic [CW-1:0] drop_count;

    keyed_write_guard #(.ADDR_W(8), .CNT_W(CW)) i_keyed_write_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .locked     (locked),
        .drop_count (drop_count)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [NR-1:0] we;
        logic [31:0]   data;
        logic          lk;
        logic [CW-1:0] cnt;
        string         req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // Reference model state: 0 closed, 1 first key seen, 2 open
    int            m_st  = 0;
    logic [CW-1:0] m_cnt = '0;

    // Protected index from the R2 map, -1 when not protected
    function automatic int map_idx(input logic [7:0] a);
        case (a)
            8'h00: return 0;   8'h04: return 1;   8'h08: return 2;
            8'h0C: return 3;   8'h10: return 4;   8'h14: return 5;
            8'h20: return 6;   8'h24: return 7;   8'h28: return 8;
            8'h2C: return 9;   8'h30: return 10;  8'h34: return 11;
            8'h40: return 12;  8'h44: return 13;  8'h48: return 14;
            8'h54: return 15;  8'h7C: return 16;
            8'h80: return 17;  8'h84: return 18;  8'h88: return 19;
            8'h8C: return 20;  8'h90: return 21;  8'h94: return 22;
            8'h98: return 23;
            default: return -1;
        endcase
    endfunction

    // Driver: present one write, update the model, push the expected outcome
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        exp_t e;
        int   ix;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        e.we = '0; e.data = d;
        ix = map_idx(a);
        if (a == 8'h6C) begin
            if (d != KA) m_st = 0; else if (m_st == 0) m_st = 1;
        end else if (a == 8'h70) begin
            if (d != KB) m_st = 0; else if (m_st == 1) m_st = 2;
        end else if (ix >= 0) begin
            if (m_st == 2) e.we[ix] = 1'b1;
            else if (m_cnt != '1) m_cnt = m_cnt + 1'b1;
        end
        e.lk = (m_st != 2); e.cnt = m_cnt; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input string req);
        exp_t e;
        @(negedge clk);
        wr_en = 1'b0;
        e.we = '0; e.data = '0; e.lk = (m_st != 2); e.cnt = m_cnt; e.req = req;
        q.push_back(e);
    endtask

    task automatic unlock(input string req);
        wr(8'h6C, KA, req);
        wr(8'h70, KB, req);
    endtask

    // Monitor: compare one expected entry per cycle, just after the rising edge
    always begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (reg_we !== e.we || locked !== e.lk || drop_count !== e.cnt ||
                (e.we != '0 && reg_wdata !== e.data)) begin
                errors++;
                $display("FAIL %s: we=%h lk=%b cnt=%0d wdata=%h expected we=%h lk=%b cnt=%0d wdata=%h",
                         e.req, reg_we, locked, drop_count, reg_wdata,
                         e.we, e.lk, e.cnt, e.data);
            end
        end
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state while held
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (locked !== 1'b1 || reg_we !== '0 || drop_count !== '0) begin
            errors++;
            $display("FAIL R1: lk=%b we=%h cnt=%0d expected lk=1 we=0 cnt=0",
                     locked, reg_we, drop_count);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 after release");

        // R6: closed guard drops a protected write
        wr(8'h04, 32'hAAAA_0001, "R6 dropped while closed");
        idle("R6 idle");
        // R4: second key alone keeps it closed
        wr(8'h70, KB, "R4 key B alone");
        wr(8'h40, 32'h1, "R4 dropped after key B alone");
        // R4: first key alone keeps it closed
        wr(8'h6C, KA, "R4 key A alone");
        wr(8'h44, 32'h2, "R4 dropped while armed");
        // R3: correct order opens
        unlock("R3 unlock");
        // R2/R9: every protected offset, each with distinct data
        for (int i = 0; i < NR; i++) begin
            logic [7:0] a;
            if (i < 6)       a = 8'(i * 4);
            else if (i < 12) a = 8'(8'h20 + (i - 6) * 4);
            else if (i == 12) a = 8'h40;
            else if (i == 13) a = 8'h44;
            else if (i == 14) a = 8'h48;
            else if (i == 15) a = 8'h54;
            else if (i == 16) a = 8'h7C;
            else if (i < 23)  a = 8'(8'h80 + (i - 17) * 4);
            else              a = 8'h98;
            wr(a, 32'hC0DE_0000 + 32'(i), "R2 R9 map and data");
        end
        idle("R2 enable lasts one cycle");
        // R7: unmapped offsets while open
        wr(8'h4C, 32'h5, "R7 unmapped open");
        wr(8'h60, 32'h6, "R7 unmapped open");
        // R8: key rewrites with correct words stay open, no enable
        wr(8'h6C, KA, "R8 key A while open");
        wr(8'h70, KB, "R8 key B while open");
        wr(8'h54, 32'h0000_0048, "R2 oscillator write while open");
        // R5: zero to key A closes
        wr(8'h6C, 32'h0, "R5 zero key A");
        wr(8'h98, 32'h7, "R6 dropped after relock");
        // R5: wrong word to key B closes
        unlock("R3 unlock again");
        wr(8'h70, 32'h1234_5678, "R5 wrong key B");
        wr(8'h00, 32'h8, "R6 dropped after wrong key");
        // R5: zero to key B closes
        unlock("R3 unlock third");
        wr(8'h08, 32'h9, "R2 open write");
        wr(8'h70, 32'h0, "R5 zero key B");
        // R7: unmapped while closed not counted
        wr(8'h50, 32'hA, "R7 unmapped closed");
        // R10: drive drops to saturation
        for (int k = 0; k < 20; k++) wr(8'h48, 32'(k), "R10 saturating count");
        idle("R10 holds");
        // R8: key writes while closed never counted
        wr(8'h6C, 32'h0, "R8 key write closed");
        idle("final idle");

        wait (q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule